// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed binary-coded decimal: seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year, plus a century bit. It divides a free-running time-base enable (nominally 32.768 kHz) down to one advance per second. The carry ripples from seconds up to years. Month lengths and leap years are applied automatically.

Eight byte-wide registers sit behind a simple synchronous write port and a combinational read port, so a serial bus front end can load and fetch them. Some single bits share bytes with the time fields: a halt bit sharing the seconds byte, a sticky oscillator-fault flag sharing the minutes byte, and a century enable and century bit sharing the hours byte. A control byte sets the level of an open-drain style output. Any write to a time byte also restarts the sub-second phase, so the next advance comes one full second later.

Top module: `bcd_rtc_core`

## Requirements
- R1: Byte layout: 0 = {halt, seconds[6:0]}, 1 = {fault, minutes[6:0]}, 2 = {century enable, century bit, hours[5:0]}, 3 = day of week in bits 2:0, 4 = date in bits 5:0, 5 = month in bits 4:0, 6 = year, 7 = {output level, 7 zero bits}. Bits outside these fields read back 0 whatever was written.
- R2: Seconds and minutes count 00-59 and hours 00-23 in BCD. Each wraps and carries into the next field. Seconds advance once per TICKS_PER_SEC base ticks taken while the oscillator runs and halt is 0.
- R3: Day of week counts 1 to 7 and goes back to 1. It advances on every hour wrap, together with the date.
- R4: The date wraps to 01 after day 30 in April, June, September and November, and after day 31 in the other months except February. Month 12 wraps to 01 and carries into the year.
- R5: February ends on day 29 when the BCD year is divisible by 4 (00 included) and on day 28 otherwise.
- R6: Year 99 wraps to 00. On that wrap the century bit inverts when the century enable is 1.
- R7: With century enable 0, the century bit changes only by a write to byte 2.
- R8: Writing halt = 1 freezes every time field. Writing halt = 0 lets counting resume.
- R9: The fault flag is set whenever the oscillator-running input is 0 or halt is 1. Otherwise it keeps its value until a write to byte 1 with bit 7 = 0 clears it.
- R10: out_level equals bit 7 of byte 7: 0 drives low, 1 releases.
- R11: After reset the fault flag and the output bit are 1 and halt is 0.
- R12: A write to any of bytes 0-6 takes effect at the next clock edge. The following seconds advance needs a full TICKS_PER_SEC base ticks counted from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle time-base enable |
| osc_running | input | 1 | 1 while the oscillator is running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Contents of the addressed register |
| out_level | output | 1 | Level for the open-drain output |

## Verification
The calendar is tested at the points where field carries meet. The cases are the end of a 30-day and a 31-day month, the end of February in years 23, 24 and 00, and December 31 of year 99 with the century enable both set and clear. Each case separates one wrap limit or leap rule from its neighbours. Halt, oscillator loss and a phase-restarting write are placed mid-second, which tells a frozen or restarted prescaler apart from a free-running one. A behavioural model in the bench compares all eight bytes and the output on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd8_t;

  localparam int unsigned REG_COUNT = 8;
  localparam int unsigned ADDR_W    = $clog2(REG_COUNT);

  // Byte positions: the carry chain runs in this order.
  localparam int unsigned A_SEC  = 0;
  localparam int unsigned A_MIN  = 1;
  localparam int unsigned A_HOUR = 2;
  localparam int unsigned A_DOW  = 3;
  localparam int unsigned A_DATE = 4;
  localparam int unsigned A_MON  = 5;
  localparam int unsigned A_YEAR = 6;
  localparam int unsigned A_CTRL = 7;

  // Bits that a write stores into a counting field.
  function automatic bcd8_t field_mask(input int unsigned idx);
    case (idx)
      A_SEC, A_MIN: return 8'h7F;
      A_HOUR:       return 8'h3F;
      A_DOW:        return 8'h07;
      A_DATE:       return 8'h3F;
      A_MON:        return 8'h1F;
      A_YEAR:       return 8'hFF;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by 4: even tens with ones 0/4/8, or odd tens with ones 2/6.
  function automatic logic is_leap(input bcd8_t yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_last_day(input bcd8_t mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic run,
  input  logic restart,
  output logic sec_pulse
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          step, at_last;

  always_comb begin
    step      = run && base_tick;
    at_last   = (cnt_q == LAST);
    sec_pulse = step && at_last && !restart;
    cnt_d     = cnt_q;
    if (restart)   cnt_d = '0;
    else if (step) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter rtc_pkg::bcd8_t FLOOR = 8'h00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  rtc_pkg::bcd8_t ceil,
  input  logic           ld,
  input  rtc_pkg::bcd8_t ld_val,
  output rtc_pkg::bcd8_t val,
  output logic           wrap
);
  rtc_pkg::bcd8_t val_q, val_d;
  logic           at_top;

  always_comb begin
    at_top = (val_q >= ceil);
    wrap   = adv && at_top;
    val_d  = val_q;
    if (ld)       val_d = ld_val;
    else if (adv) val_d = at_top ? FLOOR : rtc_pkg::bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FLOOR;
    else        val_q <= val_d;
  end

  assign val = val_q;
endmodule

// File: rtl/rtc_ctrl_flags.sv
module rtc_ctrl_flags (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_running,
  input  logic           sel_sec,
  input  logic           sel_min,
  input  logic           sel_hour,
  input  logic           sel_ctrl,
  input  rtc_pkg::bcd8_t wr_data,
  input  logic           year_wrap,
  output logic           halt,
  output logic           fault,
  output logic           cen_en,
  output logic           cen_bit,
  output logic           out_bit
);
  logic halt_q, fault_q, cen_en_q, cen_bit_q, out_q;
  logic halt_d, fault_d, cen_en_d, cen_bit_d, out_d;

  always_comb begin
    halt_d    = sel_sec  ? wr_data[7] : halt_q;
    cen_en_d  = sel_hour ? wr_data[7] : cen_en_q;
    out_d     = sel_ctrl ? wr_data[7] : out_q;
    cen_bit_d = cen_bit_q;
    if (sel_hour)                   cen_bit_d = wr_data[6];
    else if (year_wrap && cen_en_q) cen_bit_d = ~cen_bit_q;
    fault_d = fault_q;
    if (!osc_running || halt_q) fault_d = 1'b1;
    else if (sel_min)           fault_d = wr_data[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      fault_q   <= 1'b1;
      cen_en_q  <= 1'b0;
      cen_bit_q <= 1'b0;
      out_q     <= 1'b1;
    end else begin
      halt_q    <= halt_d;
      fault_q   <= fault_d;
      cen_en_q  <= cen_en_d;
      cen_bit_q <= cen_bit_d;
      out_q     <= out_d;
    end
  end

  assign halt    = halt_q;
  assign fault   = fault_q;
  assign cen_en  = cen_en_q;
  assign cen_bit = cen_bit_q;
  assign out_bit = out_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       base_tick,
  input  logic                       osc_running,
  input  logic                       wr_en,
  input  logic [rtc_pkg::ADDR_W-1:0] wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic [rtc_pkg::ADDR_W-1:0] rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       out_level
);
  import rtc_pkg::*;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  logic [REG_COUNT-1:0] wr_sel;
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  logic time_wr;
  assign time_wr = |wr_sel[A_YEAR:A_SEC];

  logic halt, fault, cen_en, cen_bit, out_bit;
  logic sec_pulse;

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .base_tick (base_tick),
    .run       (osc_running && !halt),
    .restart   (time_wr),
    .sec_pulse (sec_pulse)
  );

  bcd8_t sec_v, min_v, hour_v, dow_v, date_v, mon_v, year_v;
  logic  sec_w, min_w, hour_w, dow_w, date_w, mon_w, year_w;
  bcd8_t date_ceil;

  assign date_ceil = month_last_day(mon_v, is_leap(year_v));

  rtc_bcd_field #(.FLOOR(8'h00)) u_sec (
    .clk(clk), .rst_n(core_rst_n), .adv(sec_pulse), .ceil(8'h59),
    .ld(wr_sel[A_SEC]), .ld_val(wr_data & field_mask(A_SEC)),
    .val(sec_v), .wrap(sec_w));

  rtc_bcd_field #(.FLOOR(8'h00)) u_min (
    .clk(clk), .rst_n(core_rst_n), .adv(sec_w), .ceil(8'h59),
    .ld(wr_sel[A_MIN]), .ld_val(wr_data & field_mask(A_MIN)),
    .val(min_v), .wrap(min_w));

  rtc_bcd_field #(.FLOOR(8'h00)) u_hour (
    .clk(clk), .rst_n(core_rst_n), .adv(min_w), .ceil(8'h23),
    .ld(wr_sel[A_HOUR]), .ld_val(wr_data & field_mask(A_HOUR)),
    .val(hour_v), .wrap(hour_w));

  rtc_bcd_field #(.FLOOR(8'h01)) u_dow (
    .clk(clk), .rst_n(core_rst_n), .adv(hour_w), .ceil(8'h07),
    .ld(wr_sel[A_DOW]), .ld_val(wr_data & field_mask(A_DOW)),
    .val(dow_v), .wrap(dow_w));

  rtc_bcd_field #(.FLOOR(8'h01)) u_date (
    .clk(clk), .rst_n(core_rst_n), .adv(hour_w), .ceil(date_ceil),
    .ld(wr_sel[A_DATE]), .ld_val(wr_data & field_mask(A_DATE)),
    .val(date_v), .wrap(date_w));

  rtc_bcd_field #(.FLOOR(8'h01)) u_mon (
    .clk(clk), .rst_n(core_rst_n), .adv(date_w), .ceil(8'h12),
    .ld(wr_sel[A_MON]), .ld_val(wr_data & field_mask(A_MON)),
    .val(mon_v), .wrap(mon_w));

  rtc_bcd_field #(.FLOOR(8'h00)) u_year (
    .clk(clk), .rst_n(core_rst_n), .adv(mon_w), .ceil(8'h99),
    .ld(wr_sel[A_YEAR]), .ld_val(wr_data & field_mask(A_YEAR)),
    .val(year_v), .wrap(year_w));

  rtc_ctrl_flags u_flags (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .osc_running (osc_running),
    .sel_sec     (wr_sel[A_SEC]),
    .sel_min     (wr_sel[A_MIN]),
    .sel_hour    (wr_sel[A_HOUR]),
    .sel_ctrl    (wr_sel[A_CTRL]),
    .wr_data     (wr_data),
    .year_wrap   (year_w),
    .halt        (halt),
    .fault       (fault),
    .cen_en      (cen_en),
    .cen_bit     (cen_bit),
    .out_bit     (out_bit)
  );

  logic unused_w;
  assign unused_w = dow_w;

  always_comb begin
    case (rd_addr)
      ADDR_W'(A_SEC):  rd_data = {halt, sec_v[6:0]};
      ADDR_W'(A_MIN):  rd_data = {fault, min_v[6:0]};
      ADDR_W'(A_HOUR): rd_data = {cen_en, cen_bit, hour_v[5:0]};
      ADDR_W'(A_DOW):  rd_data = dow_v;
      ADDR_W'(A_DATE): rd_data = date_v;
      ADDR_W'(A_MON):  rd_data = mon_v;
      ADDR_W'(A_YEAR): rd_data = year_v;
      default:         rd_data = {out_bit, 7'b0};
    endcase
  end

  assign out_level = out_bit;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic                       clk,
  input logic                       core_rst_n,
  input logic                       wr_en,
  input logic [rtc_pkg::ADDR_W-1:0] wr_addr,
  input logic [7:0]                 wr_data,
  input logic                       osc_running,
  input logic                       out_level,
  input logic                       halt,
  input logic                       fault,
  input logic                       cen_en,
  input logic                       cen_bit,
  input rtc_pkg::bcd8_t             sec_v,
  input rtc_pkg::bcd8_t             min_v,
  input logic                       sec_pulse
);
  import rtc_pkg::*;

  logic wr_ctrl, wr_min, wr_hour, wr_time;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_min  = wr_en && (wr_addr == ADDR_W'(A_MIN));
  assign wr_hour = wr_en && (wr_addr == ADDR_W'(A_HOUR));
  assign wr_time = wr_en && (wr_addr <= ADDR_W'(A_YEAR));

  AST_OUT_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    wr_ctrl |=> (out_level == $past(wr_data[7]))); // R10

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fault && !(wr_min && !wr_data[7])) |=> fault); // R9

  AST_FAULT_ON_LOSS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!osc_running || halt) |=> fault); // R9

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!core_rst_n)
    (halt && !wr_en) |=> ($stable(sec_v) && $stable(min_v))); // R8

  AST_CENTURY_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cen_en && !wr_hour) |=> $stable(cen_bit)); // R7

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!core_rst_n)
    wr_time |=> !sec_pulse); // R12
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk         (clk),
  .core_rst_n  (core_rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .osc_running (osc_running),
  .out_level   (out_level),
  .halt        (halt),
  .fault       (fault),
  .cen_en      (cen_en),
  .cen_bit     (cen_bit),
  .sec_v       (sec_v),
  .min_v       (min_v),
  .sec_pulse   (sec_pulse)
);

// File: tb/tb_bcd_rtc_core.sv
`timescale 1ns/10ps
module tb_bcd_rtc_core;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       osc_running = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       out_level;

  int n_tests = 0;
  int n_fail  = 0;
  int obs [8];

  // Reference model state, plain decimal.
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_presc;
  int m_halt, m_fault, m_ceb, m_cb, m_out;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .osc_running(osc_running),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_level(out_level));

  always #2 clk = ~clk;

  function automatic int to_bcd(int v); return (v / 10) * 16 + (v % 10); endfunction
  function automatic int from_bcd(int b); return ((b >> 4) & 15) * 10 + (b & 15); endfunction

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int expect_byte(int a);
    case (a)
      0: return m_halt * 128 + to_bcd(m_sec);
      1: return m_fault * 128 + to_bcd(m_min);
      2: return m_ceb * 128 + m_cb * 64 + to_bcd(m_hr);
      3: return m_dow;
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      6: return to_bcd(m_yr);
      default: return m_out * 128;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0, 1, 2: return "R2";
      3:       return "R3";
      4, 5:    return "R4";
      6:       return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sample_all();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.1;
      obs[a] = int'(rd_data);
      chk(tag_of(a), obs[a], expect_byte(a));
    end
    chk("R10", int'(out_level), m_out);
  endtask

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    m_presc = 0; m_halt = 0; m_fault = 1; m_ceb = 0; m_cb = 0; m_out = 1;
  endtask

  task automatic model_step();
    bit time_wr, pulse, carry;
    int nf, d;
    time_wr = wr_en && (wr_addr <= 3'd6);
    pulse = 0;
    if (time_wr) m_presc = 0;
    else if (osc_running && !m_halt && base_tick) begin
      if (m_presc == TPS - 1) begin m_presc = 0; pulse = 1; end
      else m_presc++;
    end
    if (pulse) begin
      carry = 1;
      if (m_sec >= 59) m_sec = 0; else begin m_sec++; carry = 0; end
      if (carry) begin if (m_min >= 59) m_min = 0; else begin m_min++; carry = 0; end end
      if (carry) begin if (m_hr >= 23) m_hr = 0; else begin m_hr++; carry = 0; end end
      if (carry) begin
        m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
        if (m_date >= days_in(m_mon, m_yr)) m_date = 1; else begin m_date++; carry = 0; end
      end
      if (carry) begin if (m_mon >= 12) m_mon = 1; else begin m_mon++; carry = 0; end end
      if (carry) begin
        if (m_yr >= 99) begin m_yr = 0; if (m_ceb) m_cb ^= 1; end
        else m_yr++;
      end
    end
    nf = (!osc_running || m_halt) ? 1 : ((wr_en && wr_addr == 3'd1) ? int'(wr_data[7]) : m_fault);
    if (wr_en) begin
      d = int'(wr_data);
      case (wr_addr)
        3'd0: begin m_halt = (d >> 7) & 1; m_sec = from_bcd(d & 8'h7F); end
        3'd1: m_min = from_bcd(d & 8'h7F);
        3'd2: begin m_ceb = (d >> 7) & 1; m_cb = (d >> 6) & 1; m_hr = from_bcd(d & 8'h3F); end
        3'd3: m_dow = d & 7;
        3'd4: m_date = from_bcd(d & 8'h3F);
        3'd5: m_mon = from_bcd(d & 8'h1F);
        3'd6: m_yr = from_bcd(d);
        default: m_out = (d >> 7) & 1;
      endcase
    end
    m_fault = nf;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    sample_all();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    base_tick = 1'b1;
    for (int i = 0; i < n; i++) cycle();
    base_tick = 1'b0;
  endtask

  task automatic set_time(int hr_byte, int mn, int sc, int dw, int dt, int mo, int yr);
    wr(6, yr); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, hr_byte); wr(1, mn); wr(0, sc);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sample_all();
    for (int i = 0; i < 4; i++) cycle();
    chk("R11", obs[1] >> 7, 1);
    chk("R11", obs[0] >> 7, 0);
    chk("R11", int'(out_level), 1);

    // Minute and hour carry.
    set_time(8'h09, 8'h59, 8'h59, 2, 8'h10, 8'h06, 8'h30);
    run(TPS);
    chk("R2", obs[2], 8'h10);
    chk("R2", obs[1] & 8'h7F, 8'h00);

    // Non-leap February end.
    set_time(8'h23, 8'h59, 8'h50, 7, 8'h28, 8'h02, 8'h23);
    run(TPS * 11);
    chk("R5", obs[4], 8'h01);
    chk("R5", obs[5], 8'h03);
    chk("R3", obs[3], 1);

    // Leap February in year 24, then its own end.
    set_time(8'h23, 8'h59, 8'h59, 3, 8'h28, 8'h02, 8'h24);
    run(TPS);
    chk("R5", obs[4], 8'h29);
    chk("R3", obs[3], 4);
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    run(TPS);
    chk("R5", obs[4], 8'h01);
    chk("R5", obs[5], 8'h03);

    // Year 00 counts as leap.
    set_time(8'h23, 8'h59, 8'h59, 5, 8'h28, 8'h02, 8'h00);
    run(TPS);
    chk("R5", obs[4], 8'h29);

    // 30-day and 31-day months.
    set_time(8'h23, 8'h59, 8'h59, 1, 8'h30, 8'h04, 8'h11);
    run(TPS);
    chk("R4", obs[5], 8'h05);
    chk("R4", obs[4], 8'h01);
    set_time(8'h23, 8'h59, 8'h59, 1, 8'h30, 8'h01, 8'h11);
    run(TPS);
    chk("R4", obs[4], 8'h31);

    // Century toggle with enable set.
    set_time(8'hA3, 8'h59, 8'h59, 6, 8'h31, 8'h12, 8'h99);
    run(TPS);
    chk("R6", obs[6], 8'h00);
    chk("R6", (obs[2] >> 6) & 1, 1);
    // Enable clear: century bit holds.
    set_time(8'h63, 8'h59, 8'h59, 6, 8'h31, 8'h12, 8'h99);
    run(TPS);
    chk("R7", obs[6], 8'h00);
    chk("R7", (obs[2] >> 6) & 1, 1);

    // Halt freezes and sets the fault flag.
    wr(0, 8'h90);
    run(TPS * 5);
    chk("R8", obs[0], 8'h90);
    chk("R9", obs[1] >> 7, 1);
    wr(0, 8'h10);
    wr(1, 8'h05);
    chk("R9", obs[1] >> 7, 0);
    run(TPS * 2);
    chk("R8", obs[0], 8'h12);

    // Oscillator loss.
    osc_running = 1'b0;
    run(TPS * 3);
    chk("R9", obs[1] >> 7, 1);
    chk("R8", obs[0], 8'h12);
    osc_running = 1'b1;
    run(TPS * 2);
    chk("R9", obs[1] >> 7, 1);
    wr(1, 8'h05);
    chk("R9", obs[1] >> 7, 0);

    // Unused bits read as zero.
    wr(3, 8'hFF);
    chk("R1", obs[3], 8'h07);
    wr(4, 8'hD5);
    chk("R1", obs[4], 8'h15);
    wr(7, 8'h7F);
    chk("R1", obs[7], 8'h00);
    chk("R10", int'(out_level), 0);
    wr(7, 8'h80);
    chk("R10", int'(out_level), 1);

    // Write restarts the sub-second phase.
    run(2);
    wr(0, 8'h30);
    run(TPS - 1);
    chk("R12", obs[0], 8'h30);
    run(1);
    chk("R12", obs[0], 8'h31);

    // Longer free run across a minute.
    run(TPS * 70);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule